// File: doc/BRIEF.md
# Character Terminal Display Buffer

This block holds the text shown on a 16-row by 64-column character screen and keeps a cursor that marks where the next character lands. Another agent hands it 8-bit ASCII codes on a parallel port. It accepts one code on each rising edge of a strobe line. A printable code is stored at the cursor, and the cursor then moves to the right. It wraps to the next row at the right margin. At the bottom row it scrolls the whole screen up by one line.

Three control codes are understood:
- Carriage return (0x0D) sends the cursor back to the left margin.
- Line feed (0x0A) moves the cursor down one row.
- Form feed (0x0C) blanks the screen.

Every other non-printable code is dropped. A separate clear line blanks the screen and homes the cursor.

Scrolling and blanking take several cycles. While either runs, a busy flag is raised, and strobe edges that arrive during that time are not taken. A registered read port returns the code stored at any row and column, for a display scanner or a test bench. The current cursor position is also driven out.

Top module: `chr_term_buf`

## Requirements
- R1: The store has ROWS x COLS cells (default 16 x 64). rd_char shows the code held at (rd_row, rd_col) one clock after those addresses are presented. Row 0 is the top row and column 0 the left margin.
- R2: A code on data_in is taken only on a rising edge of strobe. Holding strobe high for several cycles takes that code once.
- R3: A cycle with clear high homes the cursor to row 0, column 0 on the next cycle and raises busy. When busy falls, every cell holds 0x20.
- R4: Code 0x0D sets the cursor column to 0 and leaves the row unchanged.
- R5: Code 0x0A on a row other than the last adds one to the cursor row and leaves the column unchanged.
- R6: Code 0x0C blanks every cell to 0x20 and homes the cursor. Busy stays high until the blanking is done.
- R7: A code from 0x20 to 0x7E is written to the cell under the cursor, and the column then increases by one.
- R8: A printable code written in the last column moves the cursor to column 0 of the next row.
- R9: On the last row, a line feed or a wrap makes the screen scroll:
  - every row moves up one, the top row is lost, and the bottom row becomes all 0x20;
  - the cursor stays on the last row;
  - busy is high from the next cycle until the scroll ends, and the cursor does not move while busy is high;
  - strobe edges seen while busy is high are ignored.
- R10: Codes 0x00 to 0x1F other than 0x0A, 0x0C and 0x0D are ignored, as are codes 0x7F to 0xFF. They leave the cursor and the screen unchanged.
- R11: While rst is high, the cursor is held at home. After reset the block blanks the screen with busy high, as for R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Blank screen and home cursor |
| strobe | input | 1 | Rising edge takes data_in |
| data_in | input | 8 | ASCII code |
| rd_row | input | 4 | Read port row |
| rd_col | input | 6 | Read port column |
| rd_char | output | 8 | Code at the read address, one cycle later |
| busy | output | 1 | Scroll or blanking in progress |
| cur_row | output | 4 | Cursor row |
| cur_col | output | 6 | Cursor column |

## Verification
The bench builds the block with its default 16-row, 64-column geometry. A 64-character line, a wrap that triggers a scroll, and a scroll that discards the top row therefore all happen with a few hundred strobes. Each full blanking pass takes 1024 cycles. This is short enough that form feed, clear and reset can each be run to completion and their cells read back through the read port.

// File: rtl/chr_term_pkg.sv
package chr_term_pkg;
  typedef enum logic [2:0] {
    K_NONE, K_PRINT, K_CR, K_LF, K_FF
  } code_kind_t;

  typedef enum logic [1:0] {
    ST_IDLE, ST_FILL_ALL, ST_FILL_ROW
  } term_state_t;

  localparam logic [7:0] CH_SPACE = 8'h20;
  localparam logic [7:0] CH_TILDE = 8'h7E;
  localparam logic [7:0] CH_CR    = 8'h0D;
  localparam logic [7:0] CH_LF    = 8'h0A;
  localparam logic [7:0] CH_FF    = 8'h0C;
endpackage

// File: rtl/chr_term_decode.sv
module chr_term_decode
  import chr_term_pkg::*;
(
  input  logic [7:0] code,
  output code_kind_t kind
);
  always_comb begin
    if (code >= CH_SPACE && code <= CH_TILDE) kind = K_PRINT;
    else if (code == CH_CR)                   kind = K_CR;
    else if (code == CH_LF)                   kind = K_LF;
    else if (code == CH_FF)                   kind = K_FF;
    else                                      kind = K_NONE;
  end
endmodule

// File: rtl/chr_term_mem.sv
module chr_term_mem #(
  parameter int DW = 8,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/chr_term_ctrl.sv
module chr_term_ctrl
  import chr_term_pkg::*;
#(
  parameter int ROWS = 16,
  parameter int COLS = 64
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clear,
  input  logic                         stb_edge,
  input  code_kind_t                   kind,
  output logic                         we,
  output logic                         wr_blank,
  output logic [$clog2(ROWS*COLS)-1:0] waddr,
  output logic [$clog2(ROWS)-1:0]      top_row,
  output logic [$clog2(ROWS)-1:0]      cur_row,
  output logic [$clog2(COLS)-1:0]      cur_col,
  output logic                         busy
);
  localparam int RW    = $clog2(ROWS);
  localparam int CW    = $clog2(COLS);
  localparam int AW    = RW + CW;
  localparam int DEPTH = ROWS * COLS;
  localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);
  localparam logic [CW-1:0] LAST_COL = CW'(COLS - 1);
  localparam logic [AW-1:0] LAST_ADR = AW'(DEPTH - 1);

  term_state_t   state;
  logic [AW-1:0] cnt;
  logic [RW-1:0] fill_row;
  logic [RW-1:0] phys_row;

  assign phys_row = cur_row + top_row;
  assign busy     = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      state    <= ST_FILL_ALL;
      cnt      <= '0;
      cur_row  <= '0;
      cur_col  <= '0;
      top_row  <= '0;
      fill_row <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (stb_edge) begin
            unique case (kind)
              K_PRINT: begin
                if (cur_col == LAST_COL) begin
                  cur_col <= '0;
                  if (cur_row == LAST_ROW) begin
                    top_row  <= top_row + 1'b1;
                    fill_row <= top_row;
                    cnt      <= '0;
                    state    <= ST_FILL_ROW;
                  end else begin
                    cur_row <= cur_row + 1'b1;
                  end
                end else begin
                  cur_col <= cur_col + 1'b1;
                end
              end
              K_CR: cur_col <= '0;
              K_LF: begin
                if (cur_row == LAST_ROW) begin
                  top_row  <= top_row + 1'b1;
                  fill_row <= top_row;
                  cnt      <= '0;
                  state    <= ST_FILL_ROW;
                end else begin
                  cur_row <= cur_row + 1'b1;
                end
              end
              K_FF: begin
                state   <= ST_FILL_ALL;
                cnt     <= '0;
                cur_row <= '0;
                cur_col <= '0;
                top_row <= '0;
              end
              default: ;
            endcase
          end
        end
        ST_FILL_ALL: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST_ADR) state <= ST_IDLE;
        end
        ST_FILL_ROW: begin
          cnt <= cnt + 1'b1;
          if (cnt[CW-1:0] == LAST_COL) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    we       = 1'b0;
    wr_blank = 1'b1;
    waddr    = cnt;
    unique case (state)
      ST_IDLE: begin
        we       = stb_edge && (kind == K_PRINT) && !clear && !rst;
        wr_blank = 1'b0;
        waddr    = {phys_row, cur_col};
      end
      ST_FILL_ALL: begin
        we    = 1'b1;
        waddr = cnt;
      end
      ST_FILL_ROW: begin
        we    = 1'b1;
        waddr = {fill_row, cnt[CW-1:0]};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/chr_term_buf.sv
module chr_term_buf
  import chr_term_pkg::*;
#(
  parameter int ROWS = 16,
  parameter int COLS = 64,
  parameter int DW   = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear,
  input  logic                    strobe,
  input  logic [DW-1:0]           data_in,
  input  logic [$clog2(ROWS)-1:0] rd_row,
  input  logic [$clog2(COLS)-1:0] rd_col,
  output logic [DW-1:0]           rd_char,
  output logic                    busy,
  output logic [$clog2(ROWS)-1:0] cur_row,
  output logic [$clog2(COLS)-1:0] cur_col
);
  localparam int RW = $clog2(ROWS);
  localparam int CW = $clog2(COLS);
  localparam int AW = RW + CW;

  logic          strobe_q;
  logic          stb_edge;
  code_kind_t    kind;
  logic          we;
  logic          wr_blank;
  logic [AW-1:0] waddr;
  logic [AW-1:0] raddr;
  logic [RW-1:0] top_row;
  logic [RW-1:0] rd_phys;
  logic [DW-1:0] wdata;

  always_ff @(posedge clk) begin
    if (rst) strobe_q <= 1'b0;
    else     strobe_q <= strobe;
  end

  assign stb_edge = strobe && !strobe_q;

  chr_term_decode u_dec (
    .code (data_in[7:0]),
    .kind (kind)
  );

  chr_term_ctrl #(.ROWS(ROWS), .COLS(COLS)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .clear    (clear),
    .stb_edge (stb_edge),
    .kind     (kind),
    .we       (we),
    .wr_blank (wr_blank),
    .waddr    (waddr),
    .top_row  (top_row),
    .cur_row  (cur_row),
    .cur_col  (cur_col),
    .busy     (busy)
  );

  assign wdata   = wr_blank ? DW'(CH_SPACE) : data_in;
  assign rd_phys = rd_row + top_row;
  assign raddr   = {rd_phys, rd_col};

  chr_term_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk   (clk),
    .we    (we),
    .waddr (waddr),
    .wdata (wdata),
    .raddr (raddr),
    .rdata (rd_char)
  );
endmodule

// File: rtl/chr_term_chk.sv
module chr_term_chk #(
  parameter int ROWS = 16,
  parameter int COLS = 64
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    clear,
  input logic                    strobe,
  input logic [7:0]              data_in,
  input logic                    busy,
  input logic [$clog2(ROWS)-1:0] cur_row,
  input logic [$clog2(COLS)-1:0] cur_col
);
  logic stb_q;
  logic acc;
  logic printable;
  logic last_row;
  logic last_col;

  always_ff @(posedge clk) begin
    if (rst) stb_q <= 1'b0;
    else     stb_q <= strobe;
  end

  assign acc       = strobe && !stb_q && !busy && !clear;
  assign printable = (data_in >= 8'h20) && (data_in <= 8'h7E);
  assign last_row  = (32'(cur_row) == ROWS - 1);
  assign last_col  = (32'(cur_col) == COLS - 1);

  AST_CLEAR_HOME: assert property (@(posedge clk) disable iff (rst)
    clear |=> (cur_row == '0) && (cur_col == '0) && busy); // R3

  AST_CR_LEFT: assert property (@(posedge clk) disable iff (rst)
    (acc && data_in == 8'h0D) |=> (cur_col == '0) && $stable(cur_row)); // R4

  AST_LF_DOWN: assert property (@(posedge clk) disable iff (rst)
    (acc && data_in == 8'h0A && !last_row) |=>
      (32'(cur_row) == 32'($past(cur_row)) + 1) && $stable(cur_col)); // R5

  AST_FF_HOME: assert property (@(posedge clk) disable iff (rst)
    (acc && data_in == 8'h0C) |=> (cur_row == '0) && (cur_col == '0) && busy); // R6

  AST_PRINT_ADV: assert property (@(posedge clk) disable iff (rst)
    (acc && printable && !last_col) |=>
      (32'(cur_col) == 32'($past(cur_col)) + 1) && $stable(cur_row)); // R7

  AST_WRAP_NEXT: assert property (@(posedge clk) disable iff (rst)
    (acc && printable && last_col && !last_row) |=>
      (cur_col == '0) && (32'(cur_row) == 32'($past(cur_row)) + 1)); // R8

  AST_SCROLL_BUSY: assert property (@(posedge clk) disable iff (rst)
    (acc && last_row && (data_in == 8'h0A || (printable && last_col))) |=>
      busy && last_row); // R9

  AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (busy && !clear) |=> $stable(cur_row) && $stable(cur_col)); // R9

  AST_IGNORE_CODE: assert property (@(posedge clk) disable iff (rst)
    (acc && !printable && data_in != 8'h0A && data_in != 8'h0C && data_in != 8'h0D)
      |=> $stable(cur_row) && $stable(cur_col) && !busy); // R10
endmodule

bind chr_term_buf chr_term_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .clear   (clear),
  .strobe  (strobe),
  .data_in (data_in[7:0]),
  .busy    (busy),
  .cur_row (cur_row),
  .cur_col (cur_col)
);

// File: tb/chr_term_buf_tb.sv
module chr_term_buf_tb;
  localparam int ROWS = 16;
  localparam int COLS = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clear = 1'b0;
  logic       strobe = 1'b0;
  logic [7:0] data_in = 8'h00;
  logic [3:0] rd_row = '0;
  logic [5:0] rd_col = '0;
  logic [7:0] rd_char;
  logic       busy;
  logic [3:0] cur_row;
  logic [5:0] cur_col;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  chr_term_buf #(.ROWS(ROWS), .COLS(COLS), .DW(8)) u_dut (
    .clk(clk), .rst(rst), .clear(clear), .strobe(strobe), .data_in(data_in),
    .rd_row(rd_row), .rd_col(rd_col), .rd_char(rd_char), .busy(busy),
    .cur_row(cur_row), .cur_col(cur_col)
  );

  // vector: {code[17:10], row[9:6], col[5:0]} expected cursor after the code
  localparam int NV = 12;
  localparam logic [17:0] VEC [NV] = '{
    {8'h48, 4'd0, 6'd1}, {8'h69, 4'd0, 6'd2}, {8'h0D, 4'd0, 6'd0},
    {8'h0A, 4'd1, 6'd0}, {8'h00, 4'd1, 6'd0}, {8'h7F, 4'd1, 6'd0},
    {8'hFF, 4'd1, 6'd0}, {8'h09, 4'd1, 6'd0}, {8'h7E, 4'd1, 6'd1},
    {8'h20, 4'd1, 6'd2}, {8'h0A, 4'd2, 6'd2}, {8'h5A, 4'd2, 6'd3}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic pulse(input logic [7:0] code);
    @(negedge clk);
    data_in = code;
    strobe  = 1'b1;
    @(negedge clk);
    strobe  = 1'b0;
  endtask

  task automatic send(input logic [7:0] code);
    pulse(code);
    wait_idle();
  endtask

  task automatic rd(input int r, input int c, output logic [7:0] v);
    @(negedge clk);
    rd_row = 4'(r);
    rd_col = 6'(c);
    @(negedge clk);
    v = rd_char;
  endtask

  task automatic chk_cell(input int r, input int c, input logic [7:0] exp, input string tag);
    logic [7:0] v;
    rd(r, c, v);
    chk(v == exp, tag, v, exp);
  endtask

  task automatic chk_cur(input int r, input int c, input string tag);
    chk(cur_row == 4'(r) && cur_col == 6'(c), tag, {cur_row, 2'b00, cur_col}, {r[3:0], 2'b00, c[5:0]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(busy == 1'b1, "R11 busy after reset", busy, 1);
    chk_cur(0, 0, "R11 cursor home after reset");
    wait_idle();
    chk_cell(7, 33, 8'h20, "R11 cell blank after reset");
    chk_cell(15, 63, 8'h20, "R1 R11 corner cell blank");

    // table walk: R4 R5 R7 R10
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][17:10]);
      chk_cur(int'(VEC[i][9:6]), int'(VEC[i][5:0]), $sformatf("R4 R5 R7 R10 vector %0d", i));
    end
    chk_cell(0, 0, 8'h48, "R1 R7 cell 0,0");
    chk_cell(0, 1, 8'h69, "R7 cell 0,1");
    chk_cell(0, 2, 8'h20, "R10 cell 0,2 untouched");
    chk_cell(1, 0, 8'h7E, "R7 tilde stored");
    chk_cell(1, 1, 8'h20, "R7 space stored");
    chk_cell(2, 2, 8'h5A, "R7 cell 2,2");

    // R2: held strobe takes one code
    @(negedge clk);
    data_in = 8'h41;
    strobe  = 1'b1;
    repeat (5) @(negedge clk);
    strobe = 1'b0;
    wait_idle();
    chk_cur(2, 4, "R2 held strobe advances once");
    chk_cell(2, 3, 8'h41, "R2 code stored once");
    chk_cell(2, 4, 8'h20, "R2 no repeat write");

    // R6 form feed, R9 strobe ignored while busy
    pulse(8'h0C);
    chk(busy == 1'b1, "R6 busy during form feed", busy, 1);
    chk_cur(0, 0, "R6 home on form feed");
    pulse(8'h51);
    wait_idle();
    chk_cur(0, 0, "R9 strobe while busy ignored");
    chk_cell(0, 0, 8'h20, "R6 R9 cell blank");
    chk_cell(2, 3, 8'h20, "R6 old text gone");

    // R8 wrap
    for (int i = 0; i < COLS; i++) send(8'h61 + 8'(i % 26));
    chk_cur(1, 0, "R8 wrap to next row");
    chk_cell(0, 63, 8'h61 + 8'(63 % 26), "R8 last column stored");
    send(8'h42);
    chk_cell(1, 0, 8'h42, "R8 next row write");

    // R9 scroll by line feed: row 0 holds wrapped text, row 1 'B'
    for (int i = 0; i < 14; i++) send(8'h0A);
    chk_cur(15, 1, "R5 reached last row");
    send(8'h43);
    pulse(8'h0A);
    chk(busy == 1'b1, "R9 busy during scroll", busy, 1);
    chk_cur(15, 2, "R9 cursor stays last row");
    wait_idle();
    chk_cell(0, 0, 8'h42, "R9 row moved up");
    chk_cell(14, 1, 8'h43, "R9 last row moved up");
    chk_cell(15, 1, 8'h20, "R9 bottom row blank");

    // R9 scroll by wrap
    send(8'h0D);
    for (int i = 0; i < COLS - 1; i++) send(8'h2E);
    chk_cur(15, 63, "R7 at last column");
    pulse(8'h57);
    chk(busy == 1'b1, "R8 R9 wrap scroll busy", busy, 1);
    chk_cur(15, 0, "R8 R9 wrap on last row");
    wait_idle();
    chk_cell(14, 63, 8'h57, "R9 wrapped row moved up");
    chk_cell(13, 1, 8'h43, "R9 second scroll");
    chk_cell(15, 63, 8'h20, "R9 new bottom row blank");

    // R3 clear
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    chk(busy == 1'b1, "R3 busy after clear", busy, 1);
    chk_cur(0, 0, "R3 home after clear");
    wait_idle();
    chk_cell(14, 63, 8'h20, "R3 cell blank after clear");
    chk_cell(0, 0, 8'h20, "R3 origin blank after clear");

    // R11 reset mid-run
    send(8'h4D);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk_cur(0, 0, "R11 home after mid reset");
    wait_idle();
    chk_cell(0, 0, 8'h20, "R11 blank after mid reset");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule